// File: doc/BRIEF.md
# ECC Memory Controller Control/Status Register File

This block is the software-visible register file of an ECC memory controller. A processor reaches it over a plain 32-bit register bus. Each access is one word, and the word is selected by the address bits above bit 1. It holds nine 32-bit registers: a mode/enable word, a delay word, a fault status word, a video configuration word, two fault address words, a diagnostic word and two event counters. The error-correction datapath, DRAM timing and refresh logic sit outside the block. They reach it through one pulse input that raises the level interrupt. Software lowers the interrupt by writing the fault status word.

A `VARIANT` parameter (0, 1 or 2) picks one of three chip flavours. The variant sets which bits of the mode word software can write, the read-only identity byte in the top of that word, and which mode bits survive a soft reset. Variant 0 also has a separate 4-byte diagnostic window with byte-wide access.

There are two resets. An asynchronous power-on reset clears everything and loads the identity byte. A synchronous soft reset restores the reset values but keeps the variant's retained mode bits.

Top module: `ecc_ctl_regs`

## Requirements
- R1: The word index is `addr[ADDR_W-1:2]`: 0 mode, 1 delay, 2 fault status, 3 video config, 4 fault address 0, 5 fault address 1, 6 diagnostic, 7 event counter 0, 8 event counter 1. `rdata` shows the selected word combinationally. A write on a clock edge with `wr_en` high is visible from the next cycle.
- R2: After power-on reset the mode word is `{VARIANT[3:0], 4'h0, 24'h0}` for variants 1 and 2 and zero for variant 0. Mode bits [31:24] never change afterwards.
- R3: On a mode write, variant 0 stores `wdata & 32'h0000_0103`. Variants 1 and 2 store the identity byte OR (`wdata & 32'h0000_0BFF`).
- R4: A delay write stores `wdata & 32'h7FFF_FFFF`, so delay bit 31 always reads as 0.
- R5: A fault status write stores all 32 bits of `wdata`, and `irq` is low the next cycle unless `irq_set` is high in the same cycle.
- R6: `irq_set` high on a clock edge makes `irq` high from the next cycle. It stays high until a fault status write or a reset, and it wins over a fault status write in the same cycle.
- R7: The two fault address words are read-only. They hold 32'h07C0_0000 and 0 after either reset.
- R8: Word indices 9 and above read as zero, and writes to them change no register.
- R9: Video config, diagnostic and event counters 0 and 1 store all 32 written bits. Each is independent of the others.
- R10: Soft reset sets delay to 32'h20 and sets fault status, video, diagnostic, both counters and `irq` to 0. It keeps mode bits `32'h0000_0100` (variant 0) or `32'hFF00_0BFC` (variants 1, 2) and clears the rest.
- R11: Variant 0 has four byte registers selected by `diag_addr[1:0]`, written on `diag_wr_en` and read combinationally on `diag_rdata`. They are cleared by power-on reset and kept over soft reset. Other variants read 0 there and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] pick the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` |
| irq_set | input | 1 | Fault event pulse from the datapath |
| irq | output | 1 | Level interrupt |
| diag_wr_en | input | 1 | Diagnostic window byte write strobe |
| diag_addr | input | 2 | Diagnostic window byte index |
| diag_wdata | input | 8 | Diagnostic window write byte |
| diag_rdata | output | 8 | Diagnostic window read byte |

## Verification
The assertions assume that `soft_rst` and `irq_set` are never high on the same edge, since the block's ordering of those two is not checked. They also assume that `addr` is stable around the sampling edge, because read data is combinational. The stimulus drives every input on the falling edge and never pulses `soft_rst` together with `irq_set`. It sweeps all sixteen word indices with several bit patterns on all three variants at once. The interrupt tie between a set pulse and a status write is exercised on purpose, because the bench expects the set to win.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_REGS   = 9;
  localparam int DIAG_BYTES = 4;

  localparam int IX_MODE   = 0;
  localparam int IX_DELAY  = 1;
  localparam int IX_FSTAT  = 2;
  localparam int IX_VIDEO  = 3;
  localparam int IX_FADDR0 = 4;
  localparam int IX_FADDR1 = 5;
  localparam int IX_DIAG   = 6;
  localparam int IX_EVCNT0 = 7;
  localparam int IX_EVCNT1 = 8;

  // Read-only identity byte placed in the mode word.
  function automatic logic [DATA_W-1:0] mode_ident(input int variant);
    logic [3:0] impl;
    impl = 4'(variant);
    return (variant == 0) ? '0 : {impl, 4'h0, 24'h0};
  endfunction

  // Bits software may change in the mode word.
  function automatic logic [DATA_W-1:0] mode_wmask(input int variant);
    return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  // Bits of the mode word that survive a soft reset.
  function automatic logic [DATA_W-1:0] mode_keep(input int variant);
    return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

  function automatic logic [DATA_W-1:0] mode_write_value(input int variant,
                                                         input logic [DATA_W-1:0] wd);
    return mode_ident(variant) | (wd & mode_wmask(variant));
  endfunction

  // Reset value of the plain registers (index 1..8).
  function automatic logic [DATA_W-1:0] plain_reset(input int idx);
    case (idx)
      IX_DELAY:  return 32'h0000_0020;
      IX_FADDR0: return 32'h07C0_0000;
      default:   return '0;
    endcase
  endfunction

  // Writable bits of the plain registers (index 1..8).
  function automatic logic [DATA_W-1:0] plain_wmask(input int idx);
    case (idx)
      IX_DELAY:             return 32'h7FFF_FFFF;
      IX_FADDR0, IX_FADDR1: return 32'h0000_0000;
      default:              return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ecc_reg_decode.sv
module ecc_reg_decode
  import ecc_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  output logic [NUM_REGS-1:0] wr_strobe,
  output logic [ADDR_W-3:0]   word_idx,
  output logic                idx_mapped
);
  localparam int IDX_W = ADDR_W - 2;

  assign word_idx   = addr[ADDR_W-1:2];
  assign idx_mapped = (int'(word_idx) < NUM_REGS);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_strobe
    assign wr_strobe[k] = wr_en && (word_idx == IDX_W'(k));
  end

  logic [1:0] unused_lsb;
  assign unused_lsb = addr[1:0];
endmodule

// File: rtl/ecc_mode_reg.sv
module ecc_mode_reg
  import ecc_regs_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] IDENT = mode_ident(VARIANT);
  localparam logic [DATA_W-1:0] KEEP  = mode_keep(VARIANT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        q <= IDENT;
    else if (soft_rst) q <= q & KEEP;
    else if (wr)       q <= mode_write_value(VARIANT, wdata);
  end
endmodule

// File: rtl/ecc_plain_reg.sv
module ecc_plain_reg
  import ecc_regs_pkg::*;
#(
  parameter logic [31:0] RESET_VAL = '0,
  parameter logic [31:0] WMASK     = '1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        q <= RESET_VAL;
    else if (soft_rst) q <= RESET_VAL;
    else if (wr)       q <= (q & ~WMASK) | (wdata & WMASK);
  end
endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window
  import ecc_regs_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr,
  input  logic [1:0] byte_idx,
  input  logic [7:0] wbyte,
  output logic [7:0] rbyte
);
  if (PRESENT) begin : g_window
    logic [7:0] bytes_q [DIAG_BYTES];
    for (genvar b = 0; b < DIAG_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                          bytes_q[b] <= '0;
        else if (wr && byte_idx == 2'(b))    bytes_q[b] <= wbyte;
      end
    end
    assign rbyte = bytes_q[byte_idx];
  end else begin : g_absent
    logic unused_diag;
    assign unused_diag = ^{clk, por_n, wr, byte_idx, wbyte};
    assign rbyte = '0;
  end
endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
  import ecc_regs_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              irq_set,
  output logic              irq,
  input  logic              diag_wr_en,
  input  logic [1:0]        diag_addr,
  input  logic [7:0]        diag_wdata,
  output logic [7:0]        diag_rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_REGS-1:0] wr_strobe;
  logic [IDX_W-1:0]    word_idx;
  logic                idx_mapped;
  logic [DATA_W-1:0]   reg_q [NUM_REGS];

  ecc_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_strobe  (wr_strobe),
    .word_idx   (word_idx),
    .idx_mapped (idx_mapped)
  );

  ecc_mode_reg #(.VARIANT(VARIANT)) u_mode (
    .clk      (clk),
    .por_n    (por_n),
    .soft_rst (soft_rst),
    .wr       (wr_strobe[IX_MODE]),
    .wdata    (wdata),
    .q        (reg_q[IX_MODE])
  );

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_plain
    ecc_plain_reg #(
      .RESET_VAL (plain_reset(i)),
      .WMASK     (plain_wmask(i))
    ) u_reg (
      .clk      (clk),
      .por_n    (por_n),
      .soft_rst (soft_rst),
      .wr       (wr_strobe[i]),
      .wdata    (wdata),
      .q        (reg_q[i])
    );
  end

  // Named internal events and state for the checker.
  logic              fstat_wr_evt;
  logic [DATA_W-1:0] mode_q, faddr0_q, faddr1_q;
  assign fstat_wr_evt = wr_strobe[IX_FSTAT];
  assign mode_q       = reg_q[IX_MODE];
  assign faddr0_q     = reg_q[IX_FADDR0];
  assign faddr1_q     = reg_q[IX_FADDR1];

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (idx_mapped && word_idx == IDX_W'(k)) rdata = reg_q[k];
    end
  end

  // A new fault event takes priority over a clearing status write.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            irq <= 1'b0;
    else if (soft_rst)     irq <= 1'b0;
    else if (irq_set)      irq <= 1'b1;
    else if (fstat_wr_evt) irq <= 1'b0;
  end

  ecc_diag_window #(.PRESENT(VARIANT == 0)) u_diag (
    .clk      (clk),
    .por_n    (por_n),
    .wr       (diag_wr_en),
    .byte_idx (diag_addr),
    .wbyte    (diag_wdata),
    .rbyte    (diag_rdata)
  );
endmodule

// File: rtl/ecc_ctl_regs_chk.sv
module ecc_ctl_regs_chk
  import ecc_regs_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int ADDR_W  = 6
) (
  input logic              clk,
  input logic              por_n,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              irq_set,
  input logic              irq,
  input logic              fstat_wr_evt,
  input logic [31:0]       mode_q,
  input logic [31:0]       faddr0_q,
  input logic [31:0]       faddr1_q
);
  localparam logic [7:0] IDENT_BYTE = mode_ident(VARIANT) >> 24;

  logic [ADDR_W-3:0] chk_idx;
  assign chk_idx = addr[ADDR_W-1:2];

  AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (!por_n)
    mode_q[31:24] == IDENT_BYTE); // R2

  AST_DELAY_TOP_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (int'(chk_idx) == IX_DELAY) |-> !rdata[31]); // R4

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (fstat_wr_evt && !irq_set && !soft_rst) |=> !irq); // R5

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!por_n)
    (irq_set && !soft_rst) |=> irq); // R6

  AST_FAULT_ADDR_RO: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst |=> ($stable(faddr0_q) && $stable(faddr1_q))); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (int'(chk_idx) >= NUM_REGS) |-> (rdata == '0)); // R8

  AST_SOFT_RESET_IRQ: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> !irq); // R10
endmodule

bind ecc_ctl_regs ecc_ctl_regs_chk #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .soft_rst     (soft_rst),
  .addr         (addr),
  .rdata        (rdata),
  .irq_set      (irq_set),
  .irq          (irq),
  .fstat_wr_evt (fstat_wr_evt),
  .mode_q       (mode_q),
  .faddr0_q     (faddr0_q),
  .faddr1_q     (faddr1_q)
);

// File: tb/ecc_ctl_regs_tb.sv
module ecc_ctl_regs_tb;
  localparam int AW = 6;
  localparam int NV = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          por_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0, irq_set = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          diag_wr_en = 1'b0;
  logic [1:0]    diag_addr = '0;
  logic [7:0]    diag_wdata = '0;
  logic [31:0]   rd  [NV];
  logic          irq [NV];
  logic [7:0]    drd [NV];

  for (genvar v = 0; v < NV; v++) begin : g_var
    ecc_ctl_regs #(.VARIANT(v), .ADDR_W(AW)) u_dut (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rd[v]), .irq_set(irq_set),
      .irq(irq[v]), .diag_wr_en(diag_wr_en), .diag_addr(diag_addr),
      .diag_wdata(diag_wdata), .diag_rdata(drd[v])
    );
  end

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] mdl [NV][16];
  logic [7:0]  dmdl [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_por(input int v, input int i);
    logic [3:0] nib;
    nib = 4'(v);
    if (i == 0) return (v == 0) ? 32'h0 : {nib, 28'h0};
    if (i == 1) return 32'h20;
    if (i == 4) return 32'h07C0_0000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_wr(input int v, input int i,
                                           input logic [31:0] old, input logic [31:0] d);
    logic [3:0] nib;
    nib = 4'(v);
    case (i)
      0: return (v == 0) ? {23'h0, d[8], 6'h0, d[1:0]}
                         : {nib, 4'h0, 12'h0, d[11], 1'b0, d[9:0]};
      1: return {1'b0, d[30:0]};
      2, 3, 6, 7, 8: return d;
      default: return old;
    endcase
  endfunction

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    for (int v = 0; v < NV; v++)
      for (int i = 0; i < 16; i++) mdl[v][i] = (i < 9) ? model_por(v, i) : 32'h0;
    for (int b = 0; b < 4; b++) dmdl[b] = 8'h0;
  endtask

  task automatic bus_wr(input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {4'(i), 2'b00}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int v = 0; v < NV; v++) mdl[v][i] = model_wr(v, i, mdl[v][i], d);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); addr = {4'(i), 2'b01}; #1;
      for (int v = 0; v < NV; v++) chk(req, rd[v], mdl[v][i]);
    end
  endtask

  task automatic check_irq(input string req, input logic exp);
    #1;
    for (int v = 0; v < NV; v++) chk(req, {31'h0, irq[v]}, {31'h0, exp});
  endtask

  task automatic check_diag(input string req);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); diag_addr = 2'(b); #1;
      chk(req, {24'h0, drd[0]}, {24'h0, dmdl[b]});
      chk(req, {24'h0, drd[1]}, 32'h0);
      chk(req, {24'h0, drd[2]}, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h5A5A_5A5A;
    pats[3] = 32'h8000_0F0F; pats[4] = 32'h0000_0000;

    do_por();
    // R1 R2 R7 R8: power-on values of every index
    check_all("R2_R7_por");
    check_irq("R6_por_irq", 1'b0);

    // R1 R3 R4 R8 R9: write sweep over every index and pattern
    foreach (pats[p]) begin
      for (int i = 0; i < 16; i++) begin
        bus_wr(i, pats[p] ^ (32'h0101_0101 * 32'(i)));
        check_all("R1_R3_R4_R8_R9_sweep");
      end
    end

    // R9: counter 1 independent of counter 0
    bus_wr(7, 32'h1111_2222);
    bus_wr(8, 32'h3333_4444);
    check_all("R9_counters");

    // R10: soft reset retains selected mode bits
    bus_wr(0, 32'hFFFF_FFFF);
    bus_wr(2, 32'hDEAD_BEEF);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      mdl[v][0] = (v == 0) ? {23'h0, mdl[v][0][8], 8'h0}
                           : {mdl[v][0][31:24], 12'h0, mdl[v][0][11], 1'b0, mdl[v][0][9:2], 2'b0};
      for (int i = 1; i < 9; i++) mdl[v][i] = model_por(v, i);
    end
    check_all("R10_soft_reset");

    // R6 R5: interrupt raise, hold, clear, tie
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    check_irq("R6_raise", 1'b1);
    @(negedge clk);
    check_irq("R6_hold", 1'b1);
    bus_wr(2, 32'h0000_1234);
    check_irq("R5_clear", 1'b0);
    check_all("R5_status_value");
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    @(negedge clk);
    irq_set = 1'b1; wr_en = 1'b1; addr = 6'(2 << 2); wdata = 32'h0000_00AA;
    @(negedge clk);
    irq_set = 1'b0; wr_en = 1'b0;
    for (int v = 0; v < NV; v++) mdl[v][2] = 32'h0000_00AA;
    check_irq("R6_tie_set_wins", 1'b1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    for (int v = 0; v < NV; v++) mdl[v][2] = 32'h0;
    check_irq("R10_irq_cleared", 1'b0);

    // R11: diagnostic byte window
    check_diag("R11_diag_por");
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      diag_wr_en = 1'b1; diag_addr = 2'(b); diag_wdata = 8'(8'h3C + 8'h11 * b);
      @(negedge clk); diag_wr_en = 1'b0;
      dmdl[b] = 8'(8'h3C + 8'h11 * b);
    end
    check_diag("R11_diag_write");
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check_diag("R11_diag_soft_keep");
    do_por();
    check_diag("R11_diag_por_clear");
    check_all("R2_repor");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule